// File: doc/BRIEF.md
# Interleaved Strided Address Generator

This block produces the sequence of quadword addresses for a transfer channel working in interleave mode. The channel moves a run of quadwords, steps over a gap of quadwords without moving anything, and repeats. It stops once a total quadword budget has been used up. A quadword is 16 bytes, and every address the block drives is aligned to 16 bytes.

The controlling logic presents four values and pulses `start` with the mode input set to interleave. The four values are the start address, the total count, the run length and the gap length. The block then raises `valid` with the current address. A downstream memory port accepts each beat by holding `ready` high in a cycle where `valid` is high. When the final beat has been accepted, the block pulses `done` for one cycle. That beat may fall in the middle of a run. A run length or total count of zero counts as a bad setup: the block pulses `done` straight away and issues no beats.

Top module: `ilv_addr_gen`

## Requirements
- R1: While reset is held and directly after it, `valid`, `done` and `addr` are all zero.
- R2: A `start` pulse is taken only when the block is idle and `mode` holds the interleave code 2. The other codes are 0 (normal), 1 (chain) and 3 (reserved). With any of them the block raises neither `valid` nor `done`.
- R3: `valid` rises in the cycle after an accepted `start`. The first address is `start_addr` with bits 3:0 cleared, and every address driven has bits 3:0 at zero.
- R4: A beat is accepted in a cycle where both `valid` and `ready` are high. Inside a run the address grows by 16 on each accepted beat. While `ready` is low, `valid` and `addr` hold their values.
- R5: After `run_qw` accepted beats, the next address is the last beat's address plus 16 × (`skip_qw` + 1). No beat is issued for the skipped quadwords. A `skip_qw` of 0 gives contiguous addresses. Addresses wrap at 2^ADDR_W.
- R6: Exactly `total_qw` beats are accepted. `done` is high for one cycle, in the cycle after the final accepted beat, and `valid` is low in that cycle. This holds even when the final beat falls in the middle of a run.
- R7: An accepted `start` with `run_qw` = 0 or `total_qw` = 0 gives `done` in the next cycle and no beats.
- R8: A `start` pulse seen while a transfer is in progress is ignored. The address and the beat sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (one-cycle pulse) |
| mode | input | 2 | Transfer mode code; 2 selects interleave |
| start_addr | input | ADDR_W | Byte address of the first quadword |
| total_qw | input | TOT_W | Total quadwords to transfer |
| run_qw | input | RUN_W | Quadwords per transfer run |
| skip_qw | input | RUN_W | Quadwords stepped over between runs |
| ready | input | 1 | Downstream accepts the current beat |
| addr | output | ADDR_W | Current quadword address |
| valid | output | 1 | A beat is offered |
| done | output | 1 | Transfer finished (one-cycle pulse) |

## Verification
Two events can land on the same accepted beat: the end of a run, which would add the skip, and the end of the total budget, which finishes the transfer. The bench provokes this with a total count that is an exact multiple of the run length. It also provokes the mid-run finish, using a total that is not a multiple of the run length. In both cases the check is that `done` comes in the next cycle with `valid` low and no further beat, and that every earlier beat address matches a model that applies the skip at each run boundary.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int QW_SHIFT = 4;

  typedef enum logic [1:0] {
    XM_NORMAL     = 2'd0,
    XM_CHAIN      = 2'd1,
    XM_INTERLEAVE = 2'd2,
    XM_RESERVED   = 2'd3
  } xfer_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } ag_state_e;
endpackage

// File: rtl/ilv_down_ctr.sv
module ilv_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/ilv_addr_reg.sv
module ilv_addr_reg #(
  parameter int ADDR_W = 32,
  parameter int STEP_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              adv,
  input  logic [STEP_W-1:0] adv_qw,
  output logic [ADDR_W-1:0] addr
);
  import ilv_pkg::*;

  localparam int HI = ADDR_W - 1;

  function automatic logic [ADDR_W-1:0] align_qw(input logic [ADDR_W-1:0] a);
    return {a[HI:QW_SHIFT], {QW_SHIFT{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] qw_bytes(input logic [STEP_W-1:0] n);
    return ADDR_W'(n) << QW_SHIFT;
  endfunction

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= align_qw(load_addr);
    else if (adv)   addr_q <= addr_q + qw_bytes(adv_qw);
  end

  assign addr = addr_q;
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int TOT_W  = 16,
  parameter int RUN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [TOT_W-1:0]  total_qw,
  input  logic [RUN_W-1:0]  run_qw,
  input  logic [RUN_W-1:0]  skip_qw,
  input  logic              ready,
  output logic [ADDR_W-1:0] addr,
  output logic              valid,
  output logic              done
);
  import ilv_pkg::*;

  localparam int STEP_W = RUN_W + 1;

  ag_state_e        state_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] skip_q;
  logic             done_q;
  logic             run_last;
  logic             tot_last;

  // named internal events
  logic start_ok, bad_cfg, launch, beat_fire, run_end, count_end;
  logic [STEP_W-1:0] adv_qw;

  assign start_ok  = start && (state_q == ST_IDLE) && (mode == 2'(XM_INTERLEAVE));
  assign bad_cfg   = (run_qw == '0) || (total_qw == '0);
  assign launch    = start_ok && !bad_cfg;
  assign beat_fire = (state_q == ST_XFER) && ready;
  assign run_end   = beat_fire && run_last;
  assign count_end = beat_fire && tot_last;
  assign adv_qw    = run_end ? (STEP_W'(skip_q) + STEP_W'(1)) : STEP_W'(1);

  ilv_down_ctr #(.W(RUN_W)) u_run_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch || run_end),
    .load_val (launch ? run_qw : run_q),
    .dec      (beat_fire),
    .last     (run_last)
  );

  ilv_down_ctr #(.W(TOT_W)) u_tot_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .load_val (total_qw),
    .dec      (beat_fire),
    .last     (tot_last)
  );

  ilv_addr_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (launch),
    .load_addr (start_addr),
    .adv       (beat_fire),
    .adv_qw    (adv_qw),
    .addr      (addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
      skip_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= count_end || (start_ok && bad_cfg);
      if (launch) begin
        state_q <= ST_XFER;
        run_q   <= run_qw;
        skip_q  <= skip_qw;
      end else if (count_end) begin
        state_q <= ST_IDLE;
      end
    end
  end

  assign valid = (state_q == ST_XFER);
  assign done  = done_q;
endmodule

// File: rtl/ilv_addr_gen_chk.sv
module ilv_addr_gen_chk #(
  parameter int ADDR_W = 32,
  parameter int RUN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] addr,
  input logic              beat_fire,
  input logic              run_end,
  input logic              count_end,
  input logic              start_ok,
  input logic              bad_cfg,
  input logic [RUN_W-1:0]  skip_q
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (addr[3:0] == 4'h0)); // R3

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !run_end && !count_end) |=> (addr == $past(addr) + ADDR_W'(16))); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(addr))); // R4

  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_end && !count_end) |=>
      (addr == $past(addr) + ((ADDR_W'($past(skip_q)) + ADDR_W'(1)) << 4))); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    count_end |=> (done && !valid)); // R6

  AST_BAD_CFG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && bad_cfg) |=> (done && !valid)); // R7
endmodule

bind ilv_addr_gen ilv_addr_gen_chk #(.ADDR_W(ADDR_W), .RUN_W(RUN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid     (valid),
  .ready     (ready),
  .done      (done),
  .addr      (addr),
  .beat_fire (beat_fire),
  .run_end   (run_end),
  .count_end (count_end),
  .start_ok  (start_ok),
  .bad_cfg   (bad_cfg),
  .skip_q    (skip_q)
);

// File: tb/tb_ilv_addr_gen.sv
module tb_ilv_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  typedef struct packed {
    logic [31:0] sa;
    logic [15:0] tot;
    logic [7:0]  run;
    logic [7:0]  skip;
    logic [1:0]  rdy;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_1000, 16'd8, 8'd2, 8'd3,   2'd0},  // total multiple of run
    '{32'h0000_2007, 16'd7, 8'd3, 8'd1,   2'd1},  // unaligned, mid-run finish
    '{32'h0000_0300, 16'd5, 8'd4, 8'd0,   2'd2},  // no gap
    '{32'h0000_4000, 16'd6, 8'd1, 8'd255, 2'd0},  // widest gap
    '{32'hFFFF_FFE0, 16'd4, 8'd1, 8'd0,   2'd0},  // address wrap
    '{32'h0000_0050, 16'd1, 8'd5, 8'd2,   2'd1}   // single beat
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [31:0] start_addr = '0;
  logic [15:0] total_qw = '0;
  logic [7:0]  run_qw = '0;
  logic [7:0]  skip_qw = '0;
  logic        ready = 1'b0;
  logic [31:0] addr;
  logic        valid;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .start_addr(start_addr), .total_qw(total_qw), .run_qw(run_qw),
    .skip_qw(skip_qw), .ready(ready), .addr(addr), .valid(valid), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [1:0] m, input logic [31:0] sa,
                             input logic [15:0] tot, input logic [7:0] r, input logic [7:0] s);
    @(negedge clk);
    start = 1'b1; mode = m; start_addr = sa; total_qw = tot; run_qw = r; skip_qw = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input vec_t v);
    logic [31:0] ea;
    int pos, beats;
    bit prev_final, fin;
    ea = {v.sa[31:4], 4'h0};
    pos = 0; beats = 0; prev_final = 1'b0; fin = 1'b0;
    ready = 1'b0;
    pulse_start(2'd2, v.sa, v.tot, v.run, v.skip);
    chk(valid === 1'b1, "R3 valid one cycle after start", valid, 1);
    for (int cyc = 0; cyc < 5000 && !fin; cyc++) begin
      if (done) begin
        chk(prev_final && beats == int'(v.tot), "R6 done right after final beat", beats, v.tot);
        chk(valid === 1'b0, "R6 valid low with done", valid, 0);
        fin = 1'b1;
      end else begin
        prev_final = 1'b0;
        ready = (v.rdy == 2'd0) ? 1'b1 : (v.rdy == 2'd1) ? cyc[0] : (cyc % 3 != 0);
        if (valid) begin
          chk(addr === ea, "R5 beat address", addr, ea);
          chk(beats < int'(v.tot), "R6 no beat past total", beats, v.tot);
          if (ready) begin
            beats++;
            ea += 32'd16;
            pos++;
            if (pos == int'(v.run)) begin
              pos = 0;
              ea += 32'(v.skip) << 4;
            end
            if (beats == int'(v.tot)) prev_final = 1'b1;
          end
        end
        @(negedge clk);
      end
    end
    chk(fin, "R6 transfer finished", fin, 1);
    ready = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R6 done lasts one cycle", done, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0, "R1 outputs idle in reset", {valid, done}, 0);
    chk(addr === 32'h0, "R1 address zero in reset", addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && addr === 32'h0, "R1 idle after reset", addr, 0);

    // R2 non-interleave modes ignored
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      pulse_start(2'(m), 32'h100, 16'd4, 8'd2, 8'd1);
      for (int k = 0; k < 3; k++) begin
        chk(valid === 1'b0 && done === 1'b0, "R2 start ignored in other mode", {valid, done}, 0);
        @(negedge clk);
      end
    end

    // table of vectors: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) run_case(VECS[i]);

    // R7 zero run length and zero total
    pulse_start(2'd2, 32'h700, 16'd5, 8'd0, 8'd1);
    chk(done === 1'b1 && valid === 1'b0, "R7 zero run gives done", {done, valid}, 2);
    @(negedge clk);
    chk(done === 1'b0 && valid === 1'b0, "R7 zero run no beats", {done, valid}, 0);
    pulse_start(2'd2, 32'h700, 16'd0, 8'd3, 8'd1);
    chk(done === 1'b1 && valid === 1'b0, "R7 zero total gives done", {done, valid}, 2);
    @(negedge clk);
    chk(done === 1'b0 && valid === 1'b0, "R7 zero total no beats", {done, valid}, 0);

    // R8 start while busy ignored
    ready = 1'b0;
    pulse_start(2'd2, 32'h800, 16'd3, 8'd3, 8'd0);
    chk(valid === 1'b1 && addr === 32'h800, "R8 first address", addr, 32'h800);
    pulse_start(2'd2, 32'h9000, 16'd1, 8'd1, 8'd0);
    chk(addr === 32'h800, "R8 busy start ignored", addr, 32'h800);
    ready = 1'b1;
    for (int b = 0; b < 3; b++) begin
      chk(valid === 1'b1 && addr === 32'h800 + 32'(b) * 32'd16, "R8 original sequence kept",
          addr, 32'h800 + 32'(b) * 32'd16);
      @(negedge clk);
    end
    chk(done === 1'b1 && valid === 1'b0, "R8 original transfer completes", {done, valid}, 2);
    ready = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule